// File: doc/BRIEF.md
# Programmable March Test Sequencer

This block is the control engine of a programmable memory self-test. A test is held as a short bit-serial microprogram in a small program memory that the block reads one bit at a time through a bit-addressed read port. The program begins with a count of march elements. Each element then gives one address-direction bit, followed by one two-bit code per operation. The reference data bit for each read and write is not stored in the program. The block works it out from the order of the operations.

After a start request, the block runs each element over every address of the RAM under test, in ascending or descending order. At each address it issues single-cycle write or read requests and compares read data against the reference. It then moves on to the next element until the element count is used up. While the test runs, `busy` is high. At the end, `done` rises and `error` shows whether any read mismatched. A mismatch ends the test at once.

Top module: `mtest_sequencer`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `done`, `error` and `ram_req` are all 0.
- R2: A test begins only on a 0-to-1 change of `start` seen while idle; a `start` that is already high when reset is released does not begin a test.
- R3: Program bits 0, 1 and 2 hold the element count, with bit 0 as the most significant bit. A count of zero ends the test with `done`=1 and `error`=0, and no RAM request is made.
- R4: Each element begins with one direction bit. It is followed by one bit pair per operation: first a last-operation flag (1 on the element's final operation), then a type bit (0 = write, 1 = read). The next element starts at the bit that follows.
- R5: Direction 0 visits addresses from 0 up to 2^ADDR_W-1. Direction 1 visits them from 2^ADDR_W-1 down to 0.
- R6: All operations of an element run at one address before the address moves. Once the final address is done, the next element starts. The test ends after the counted number of elements.
- R7: The reference bit is 0 for the first operation of the test. It flips only when a read is followed by a write; in every other case it keeps its value. Each repeat of an element at a new address uses the same reference bits as its first address.
- R8: A read whose data differ from the reference sets `error` and `done`, clears `busy`, and stops all further RAM requests until reset.
- R9: `busy` stays high from the cycle after the start edge until the end of the test. `done` then rises with the final `error` value and both hold until reset.
- R10: Each operation is a single-cycle `ram_req` pulse. `ram_we` is 1 for writes, and `ram_wdata` carries the reference bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Test request, acted on at its rising edge |
| prog_addr | output | PC_W | Bit address into the program memory |
| prog_bit | input | 1 | Program bit at `prog_addr`, same cycle |
| ram_req | output | 1 | One-cycle operation request to the RAM interface |
| ram_we | output | 1 | 1 = write, 0 = read |
| ram_addr | output | ADDR_W | RAM cell address |
| ram_wdata | output | 1 | Write data (reference bit) |
| ram_rdata | input | 1 | Read data for `ram_addr`, same cycle |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| error | output | 1 | A read mismatched |

## Verification
The assertions assume that the program is well formed. Every counted element must hold at least one operation, its final operation must carry the last flag, and the whole program must fit in the program memory. They also assume that `prog_bit` and `ram_rdata` answer combinationally for the address the block presents in that cycle. The bench meets these assumptions by building every program from a list of elements whose last flag is placed by construction. Its program array and RAM model answer with continuous reads, and a single cell can be forced to a stuck value for the fault cases.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DIR, S_LOF, S_OTF, S_EXEC, S_NEXT, S_STOP
  } seq_state_t;

  // Reference bit for the operation that follows: flips only on read -> write.
  function automatic logic ref_after(input logic cur, input logic prev_rd, input logic now_rd);
    return (prev_rd && !now_rd) ? ~cur : cur;
  endfunction
endpackage

// File: rtl/mseq_pc.sv
`timescale 1ns/1ps
module mseq_pc #(
  parameter int PROG_BITS = 64,
  localparam int PC_W = $clog2(PROG_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            adv,
  input  logic            mark,
  input  logic            rewind,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_q, save_q;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_q + PC_W'(1);
  assign pc     = pc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pc_q   <= '0;
      save_q <= '0;
    end else begin
      if (rewind)   pc_q <= save_q;
      else if (adv) pc_q <= pc_inc;
      if (mark)     save_q <= adv ? pc_inc : pc_q;
    end
  end

  assert_rewind_R6: assert property (@(posedge clk) disable iff (rst)
    (rewind && !clear) |=> (pc_q == $past(save_q)));
endmodule

// File: rtl/mseq_addr_gen.sv
`timescale 1ns/1ps
module mseq_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_dir,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a, input logic d);
    return d ? a - ADDR_W'(1) : a + ADDR_W'(1);
  endfunction

  function automatic logic is_last(input logic [ADDR_W-1:0] a, input logic d);
    return d ? (a == '0) : (a == TOP);
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
    end else if (load) begin
      addr_q <= load_dir ? TOP : '0;
      dir_q  <= load_dir;
    end else if (step) begin
      addr_q <= next_addr(addr_q, dir_q);
    end
  end

  assign addr   = addr_q;
  assign at_end = is_last(addr_q, dir_q);

  assert_load_up_R5: assert property (@(posedge clk) disable iff (rst)
    (load && !load_dir) |=> (addr_q == '0));
  assert_load_down_R5: assert property (@(posedge clk) disable iff (rst)
    (load && load_dir) |=> (addr_q == TOP));
  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !dir_q) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && dir_q) |=> (addr_q == $past(addr_q) - ADDR_W'(1)));
endmodule

// File: rtl/mseq_ref_track.sv
`timescale 1ns/1ps
module mseq_ref_track
  import mseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic op_valid,
  input  logic op_is_read,
  input  logic snap,
  input  logic restore,
  output logic ref_bit
);
  logic ref_q, prev_rd_q, ref_sv_q, prev_sv_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ref_q     <= 1'b0;
      prev_rd_q <= 1'b0;
      ref_sv_q  <= 1'b0;
      prev_sv_q <= 1'b0;
    end else begin
      if (restore) begin
        ref_q     <= ref_sv_q;
        prev_rd_q <= prev_sv_q;
      end else if (op_valid) begin
        ref_q     <= ref_after(ref_q, prev_rd_q, op_is_read);
        prev_rd_q <= op_is_read;
      end
      if (snap) begin
        ref_sv_q  <= ref_q;
        prev_sv_q <= prev_rd_q;
      end
    end
  end

  assign ref_bit = ref_q;

  assert_keep_into_read_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !restore && !clear && op_is_read) |=> $stable(ref_q));
  assert_restore_R7: assert property (@(posedge clk) disable iff (rst)
    (restore && !clear) |=> (ref_q == $past(ref_sv_q)));
endmodule

// File: rtl/mtest_sequencer.sv
`timescale 1ns/1ps
module mtest_sequencer
  import mseq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PROG_BITS = 64,
  localparam int PC_W     = $clog2(PROG_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [PC_W-1:0]   prog_addr,
  input  logic              prog_bit,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_wdata,
  input  logic              ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              error
);
  seq_state_t       state_q;
  logic [CNT_W-1:0] noe_q;
  logic [1:0]       hdr_cnt_q;
  logic             lo_q, ot_q, first_q, start_q;
  logic             done_q, error_q;

  // Named internal events
  logic             start_rise, hdr_last, elem_begin, addr_step, addr_load;
  logic             pc_adv, rd_miss, at_end, ref_bit, last_elem;
  logic [CNT_W-1:0] noe_hdr;
  logic [ADDR_W-1:0] addr;

  assign start_rise = start && !start_q;
  assign noe_hdr    = {noe_q[CNT_W-2:0], prog_bit};
  assign hdr_last   = (state_q == S_HDR) && (hdr_cnt_q == 2'd2);
  assign last_elem  = (noe_q == CNT_W'(1));
  assign elem_begin = (hdr_last && noe_hdr != '0) ||
                      (state_q == S_NEXT && at_end && !last_elem);
  assign addr_step  = (state_q == S_NEXT) && !at_end;
  assign addr_load  = (state_q == S_DIR) && first_q;
  assign pc_adv     = (state_q == S_HDR) || (state_q == S_DIR) ||
                      (state_q == S_LOF) || (state_q == S_OTF);
  assign rd_miss    = (state_q == S_EXEC) && ot_q && (ram_rdata != ref_bit);

  mseq_pc #(.PROG_BITS(PROG_BITS)) u_pc (
    .clk(clk), .rst(rst), .clear(state_q == S_IDLE && start_rise),
    .adv(pc_adv), .mark(elem_begin), .rewind(addr_step), .pc(prog_addr));

  mseq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .load_dir(prog_bit),
    .step(addr_step), .addr(addr), .at_end(at_end));

  mseq_ref_track u_ref (
    .clk(clk), .rst(rst), .clear(state_q == S_IDLE && start_rise),
    .op_valid(state_q == S_OTF), .op_is_read(prog_bit),
    .snap(elem_begin), .restore(addr_step), .ref_bit(ref_bit));

  always_ff @(posedge clk) begin
    start_q <= start;
    if (rst) begin
      state_q   <= S_IDLE;
      noe_q     <= '0;
      hdr_cnt_q <= '0;
      lo_q      <= 1'b0;
      ot_q      <= 1'b0;
      first_q   <= 1'b0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_rise) begin
          state_q   <= S_HDR;
          hdr_cnt_q <= '0;
          noe_q     <= '0;
        end
        S_HDR: begin
          noe_q     <= noe_hdr;
          hdr_cnt_q <= hdr_cnt_q + 2'd1;
          if (hdr_last) begin
            if (noe_hdr == '0) begin
              state_q <= S_STOP;
              done_q  <= 1'b1;
            end else begin
              state_q <= S_DIR;
              first_q <= 1'b1;
            end
          end
        end
        S_DIR: begin
          first_q <= 1'b0;
          state_q <= S_LOF;
        end
        S_LOF: begin
          lo_q    <= prog_bit;
          state_q <= S_OTF;
        end
        S_OTF: begin
          ot_q    <= prog_bit;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (rd_miss) begin
            state_q <= S_STOP;
            error_q <= 1'b1;
            done_q  <= 1'b1;
          end else begin
            state_q <= lo_q ? S_NEXT : S_LOF;
          end
        end
        S_NEXT: begin
          if (!at_end) begin
            state_q <= S_DIR;
          end else if (last_elem) begin
            noe_q   <= '0;
            state_q <= S_STOP;
            done_q  <= 1'b1;
          end else begin
            noe_q   <= noe_q - CNT_W'(1);
            first_q <= 1'b1;
            state_q <= S_DIR;
          end
        end
        S_STOP:  state_q <= S_STOP;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ram_req   = (state_q == S_EXEC);
  assign ram_we    = !ot_q;
  assign ram_addr  = addr;
  assign ram_wdata = ref_bit;
  assign busy      = (state_q != S_IDLE) && (state_q != S_STOP);
  assign done      = done_q;
  assign error     = error_q;

  assert_req_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    ram_req |-> busy);
  assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !busy));
  assert_err_halts_R8: assert property (@(posedge clk) disable iff (rst)
    error |-> (done && !ram_req));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    error |=> error);
  assert_one_cycle_req_R10: assert property (@(posedge clk) disable iff (rst)
    ram_req |=> !ram_req);
  assert_begin_only_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_rise));
endmodule

// File: tb/mtest_sequencer_bench.sv
`timescale 1ns/1ps
module mtest_sequencer_bench;
  localparam int AW = 4, PB = 64, PCW = 6, DEPTH = 16, TMAX = 1024;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PCW-1:0] prog_addr;
  logic prog_bit, ram_req, ram_we, ram_wdata, ram_rdata, busy, done, error;
  logic [AW-1:0] ram_addr;

  logic [PB-1:0] prog;
  logic mem [DEPTH];
  logic stuck_en = 1'b0, stuck_v = 1'b0;
  logic [AW-1:0] stuck_a = '0;

  int total = 0, bad = 0, op_seen = 0, op_bad = 0, exp_n = 0, pp = 0;
  logic exp_we [TMAX];
  logic exp_d [TMAX];
  logic [AW-1:0] exp_a [TMAX];

  always #2.5 clk = ~clk;

  mtest_sequencer #(.ADDR_W(AW), .PROG_BITS(PB)) u_mtest_sequencer (
    .clk(clk), .rst(rst), .start(start), .prog_addr(prog_addr), .prog_bit(prog_bit),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .busy(busy), .done(done), .error(error));

  assign prog_bit  = prog[prog_addr];
  assign ram_rdata = (stuck_en && ram_addr == stuck_a) ? stuck_v : mem[ram_addr];

  always @(posedge clk) if (ram_req && ram_we) mem[ram_addr] <= ram_wdata;

  // Compare every request with the expected trace
  always @(negedge clk) begin
    if (!rst && ram_req) begin
      if (op_seen >= TMAX || op_seen >= exp_n) op_bad++;
      else if (ram_we != exp_we[op_seen] || ram_addr != exp_a[op_seen] ||
               (ram_we && ram_wdata != exp_d[op_seen])) op_bad++;
      op_seen++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic new_prog(input int count);
    prog = '0;
    prog[0] = count[2]; prog[1] = count[1]; prog[2] = count[0];
    pp = 3; exp_n = 0;
  endtask

  // ots/ds: bit k is op k's type (1 = read) and its explicit data value
  task automatic add_el(input bit dir, input int n, input logic [7:0] ots, input logic [7:0] ds);
    prog[pp] = dir; pp++;
    for (int k = 0; k < n; k++) begin
      prog[pp] = (k == n - 1); prog[pp + 1] = ots[k]; pp += 2;
    end
    for (int i = 0; i < DEPTH; i++) begin
      for (int k = 0; k < n; k++) begin
        exp_we[exp_n] = !ots[k];
        exp_a[exp_n]  = dir ? AW'(DEPTH - 1 - i) : AW'(i);
        exp_d[exp_n]  = ds[k];
        exp_n++;
      end
    end
  endtask

  function automatic int fail_len();
    for (int j = 0; j < exp_n; j++)
      if (!exp_we[j] && exp_a[j] == stuck_a && exp_d[j] != stuck_v) return j + 1;
    return exp_n;
  endfunction

  task automatic run(input string name, input bit exp_err);
    int cyc, busy_gap, ops_exp, ops_end;
    ops_exp = stuck_en ? fail_len() : exp_n;
    for (int i = 0; i < DEPTH; i++) mem[i] = i[0];
    op_seen = 0; op_bad = 0; busy_gap = 0; cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin
      if (!busy) busy_gap++;
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, {"R9 done rises ", name}, done, 1);
    check(busy_gap == 0, {"R9 busy held ", name}, busy_gap, 0);
    check(busy == 1'b0, {"R9 busy drops ", name}, busy, 0);
    check(error == exp_err, {"R8 error value ", name}, error, exp_err);
    check(op_seen == ops_exp, {"R6 op count ", name}, op_seen, ops_exp);
    check(op_bad == 0, {"R4 R5 R7 R10 op trace ", name}, op_bad, 0);
    ops_end = op_seen;
    repeat (8) @(negedge clk);
    check(op_seen == ops_end && done && error == exp_err, {"R8 halted ", name}, op_seen, ops_end);
  endtask

  task automatic prog_mats();
    new_prog(3);
    add_el(1'b0, 1, 8'h00, 8'h00);          // up(w0)
    add_el(1'b0, 2, 8'h01, 8'h02);          // up(r0,w1)
    add_el(1'b1, 3, 8'h05, 8'h01);          // down(r1,w0,r0)
  endtask

  task automatic prog_cminus();
    new_prog(6);
    add_el(1'b0, 1, 8'h00, 8'h00);
    add_el(1'b0, 2, 8'h01, 8'h02);
    add_el(1'b0, 2, 8'h01, 8'h01);
    add_el(1'b1, 2, 8'h01, 8'h02);
    add_el(1'b1, 2, 8'h01, 8'h01);
    add_el(1'b0, 1, 8'h01, 8'h00);
  endtask

  task automatic t_reset_R1();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !error && !ram_req, "R1 during reset", {busy, done, error, ram_req}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && !error && !ram_req, "R1 after reset", {busy, done, error, ram_req}, 0);
  endtask

  task automatic t_start_edge_R2();
    prog_mats();
    start = 1'b1;
    do_reset();
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && op_seen == 0, "R2 held start ignored", busy, 0);
    start = 1'b0;
    @(negedge clk);
    run("R2 mats++ after edge", 1'b0);
  endtask

  task automatic t_zero_R3();
    do_reset();
    new_prog(0);
    run("R3 zero count", 1'b0);
  endtask

  task automatic t_cminus_R6();
    do_reset();
    prog_cminus();
    run("R6 march c-", 1'b0);
  endtask

  task automatic t_readread_R7();
    do_reset();
    new_prog(3);
    add_el(1'b0, 1, 8'h00, 8'h00);          // up(w0)
    add_el(1'b1, 4, 8'h03, 8'h0C);          // down(r0,r0,w1,w1)
    add_el(1'b0, 1, 8'h01, 8'h01);          // up(r1)
    run("R7 read-read write-write", 1'b0);
  endtask

  task automatic t_stuck_R8();
    do_reset();
    prog_mats();
    stuck_en = 1'b1; stuck_a = AW'(5); stuck_v = 1'b1;
    run("R8 mats++ stuck1@5", 1'b1);
    do_reset();
    prog_cminus();
    stuck_a = AW'(10); stuck_v = 1'b0;
    run("R8 march c- stuck0@10", 1'b1);
    stuck_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 1'b0;
    prog = '0;
    t_reset_R1();
    t_start_edge_R2();
    t_zero_R3();
    t_cminus_R6();
    t_readread_R7();
    t_stuck_R8();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule